// File: doc/BRIEF.md
# Programmable interrupt countdown timer

This block is a memory-mapped down-counter meant to sit beside a processor's local interrupt logic. Software picks a clock prescale ratio, sets up a timer entry (an 8-bit interrupt vector, a mask bit and a one-shot/periodic mode bit), turns on a global enable, and then writes a start value. That write loads the live counter and restarts the prescaler. From then on the counter steps down by one on every prescaled tick.

When the count runs out, the block sends out a single-cycle interrupt request together with the programmed vector. The mask bit and the global enable can each block this request. In one-shot mode the counter stops at zero. In periodic mode it reloads the start value and keeps counting. Software can read the start value and the live count separately, each through its own 32-bit register slot.

Top module: `cdt_timer`

Register slots (byte address, bits [3:0] ignored): 0x00 control (bit 0 global enable), 0x10 timer entry (bits [7:0] vector, bit 16 mask, bit 17 periodic), 0x20 start value, 0x30 live count (read-only), 0x40 prescale code (code bits [1:0] at bits [1:0], code bit 2 at bit 3).

## Requirements
- R1: After reset every register reads 0, the live count is 0, irq_o is 0 and irq_vec_o is 0.
- R2: The 3-bit prescale code c selects the ratio 2^((c+1) mod 8). Code 7 gives divide-by-1, code 0 gives divide-by-2 and code 6 gives divide-by-128. Code bits [1:0] are stored at register bits [1:0] and code bit 2 at register bit 3. A read of the slot returns only those three bits.
- R3: Writing a nonzero start value N loads the live count with N and clears the prescaler. Each R clock cycles after that the live count drops by one, where R is the ratio.
- R4: Writing a start value of 0 stops the timer with the live count at 0, and no interrupt follows.
- R5: In one-shot mode (bit 17 = 0) the live count reaches 0 N*R cycles after the start write and then stays at 0.
- R6: In periodic mode (bit 17 = 1), on expiry the live count reloads to N, and the interrupt repeats every N*R cycles.
- R7: At expiry irq_o is high for exactly one cycle, the cycle after the expiring edge, and irq_vec_o holds the entry's vector at that time. irq_o stays low before expiry.
- R8: With the mask bit (bit 16) set, expiry raises no interrupt, yet the count still reaches 0.
- R9: With the global enable (control bit 0) clear, expiry raises no interrupt.
- R10: The control, timer-entry and start-value slots read back their writable bits. Reads return 0 for unimplemented bits, and address bits [3:0] are ignored.
- R11: Writes to the live-count slot and to unmapped slots have no effect, and unmapped slots read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the 32-bit slot |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational while req_i and !we_i |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | VEC_W | Vector delivered with irq_o |

## Verification
The assertions assume that accesses are whole 32-bit words and that a start value is written only as one access, never split. They also assume that irq_o can only follow a cycle in which the enable was set and the mask was clear. The stimulus issues single-cycle accesses at aligned slot addresses, except for one deliberate alias read. It draws start values from 2 to 12 so that one expiry pulse never runs into the next. It changes the prescale code only while the timer is being restarted.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_LVT  = 1;
  localparam int SLOT_INIT = 2;
  localparam int SLOT_CUR  = 3;
  localparam int SLOT_DIV  = 4;

  localparam int LVT_MASK_BIT = 16;
  localparam int LVT_MODE_BIT = 17;
  localparam int DIV_HI_BIT   = 3;
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8,
  parameter int DIV_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cur_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic              mask_o,
  output logic              periodic_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [DATA_W-1:0] init_o,
  output logic [DIV_W-1:0]  div_code_o,
  output logic              load_o
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  logic              wr;
  logic [DIV_W-2:0]  div_lo_q;
  logic              div_hi_q;

  assign slot   = addr_i[ADDR_W-1:4];
  assign wr     = req_i & we_i;
  assign load_o = wr && (slot == SLOT_W'(SLOT_INIT));
  assign div_code_o = {div_hi_q, div_lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      mask_o     <= 1'b0;
      periodic_o <= 1'b0;
      vec_o      <= '0;
      init_o     <= '0;
      div_lo_q   <= '0;
      div_hi_q   <= 1'b0;
    end else if (wr) begin
      case (slot)
        SLOT_W'(SLOT_CTRL): en_o <= wdata_i[0];
        SLOT_W'(SLOT_LVT): begin
          vec_o      <= wdata_i[VEC_W-1:0];
          mask_o     <= wdata_i[LVT_MASK_BIT];
          periodic_o <= wdata_i[LVT_MODE_BIT];
        end
        SLOT_W'(SLOT_INIT): init_o <= wdata_i;
        SLOT_W'(SLOT_DIV): begin
          div_lo_q <= wdata_i[DIV_W-2:0];
          div_hi_q <= wdata_i[DIV_HI_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (slot)
        SLOT_W'(SLOT_CTRL): rdata_o[0] = en_o;
        SLOT_W'(SLOT_LVT): begin
          rdata_o[VEC_W-1:0]   = vec_o;
          rdata_o[LVT_MASK_BIT] = mask_o;
          rdata_o[LVT_MODE_BIT] = periodic_o;
        end
        SLOT_W'(SLOT_INIT): rdata_o = init_o;
        SLOT_W'(SLOT_CUR):  rdata_o = cur_i;
        SLOT_W'(SLOT_DIV): begin
          rdata_o[DIV_W-2:0]  = div_lo_q;
          rdata_o[DIV_HI_BIT] = div_hi_q;
        end
        default: ;
      endcase
    end
  end

  assert_init_follows_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (init_o == $past(wdata_i)));
endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int DIV_W = 3,
  parameter int PRE_W = (1 << DIV_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             tick_o
);
  localparam int FULL_W = PRE_W + 1;

  logic [DIV_W-1:0]  shift;
  logic [FULL_W-1:0] full;
  logic [PRE_W-1:0]  lim;
  logic [PRE_W-1:0]  pre_q;

  // rotated encoding: code+1 wraps, so code 7 -> shift 0 -> divide by 1
  assign shift  = code_i + DIV_W'(1);
  assign full   = FULL_W'(1) << shift;
  assign lim    = full[PRE_W-1:0] - PRE_W'(1);
  assign tick_o = (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (clr_i || tick_o) pre_q <= '0;
    else                      pre_q <= pre_q + PRE_W'(1);
  end

  assert_clear_restarts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0));
endmodule

// File: rtl/cdt_count.sv
module cdt_count #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] init_i,
  input  logic         tick_i,
  input  logic         periodic_i,
  output logic [W-1:0] cur_o,
  output logic         expire_o
);
  logic run_q;

  assign expire_o = !load_i && tick_i && run_q && (cur_o == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cur_o <= load_val_i;
      run_q <= (load_val_i != '0);
    end else if (tick_i && run_q) begin
      if (cur_o == W'(1)) begin
        cur_o <= periodic_i ? init_i : '0;
        run_q <= periodic_i;
      end else begin
        cur_o <= cur_o - W'(1);
      end
    end
  end

  assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (cur_o == '0));

  assert_step_or_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cur_o == $past(cur_o) || cur_o == $past(cur_o) - W'(1) || cur_o == $past(init_i)));

  assert_cur_le_init_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_o <= init_i);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8,
  parameter int DIV_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic              en, mask, periodic, load, tick, expire;
  logic [VEC_W-1:0]  vec;
  logic [DATA_W-1:0] init, cur;
  logic [DIV_W-1:0]  div_code;

  cdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .cur_i(cur), .rdata_o,
    .en_o(en), .mask_o(mask), .periodic_o(periodic), .vec_o(vec),
    .init_o(init), .div_code_o(div_code), .load_o(load)
  );

  cdt_prescale #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .clr_i(load), .code_i(div_code), .tick_o(tick)
  );

  cdt_count #(.W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(wdata_i), .init_i(init),
    .tick_i(tick), .periodic_i(periodic), .cur_o(cur), .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      irq_o <= expire && en && !mask;
      if (expire && en && !mask) irq_vec_o <= vec;
    end
  end

  assert_irq_unmasked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(mask));

  assert_irq_enabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(en));

  assert_irq_vec_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_vec_o == $past(vec)));
endmodule

// File: tb/sim_cdt_timer.sv
module sim_cdt_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [7:0]  ivec;

  localparam logic [7:0] A_CTRL = 8'h00, A_LVT = 8'h10, A_INIT = 8'h20,
                         A_CUR = 8'h30, A_DIV = 8'h40, A_NONE = 8'h70;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cdt_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .irq_vec_o(ivec)
  );

  function automatic int ratio(int c);
    return 1 << ((c + 1) % 8);
  endfunction

  function automatic logic [31:0] div_word(int c);
    return (32'((c >> 2) & 1) << 3) | 32'(c & 3);
  endfunction

  function automatic logic [31:0] lvt_word(logic [7:0] v, bit m, bit p);
    return 32'(v) | (32'(m) << 16) | (32'(p) << 17);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic run(int n, int c, bit per, bit msk, bit en, logic [7:0] v);
    int r, total, mid;
    bit early;
    bit fire;
    logic [31:0] d;
    r = ratio(c); total = n * r; mid = total / 2; early = 1'b0;
    fire = en && !msk;
    wr(A_CTRL, 32'(en));
    wr(A_LVT, lvt_word(v, msk, per));
    wr(A_DIV, div_word(c));
    wr(A_INIT, 32'(n));
    for (int m = 1; m < total; m++) begin
      @(negedge clk);
      if (irq) early = 1'b1;
      if (m == mid) begin
        rd(A_CUR, d);
        chk("R3 count step", d, 32'(n - m / r));
      end
    end
    chk("R7 no early irq", 32'(early), 0);
    @(negedge clk);
    chk("R7/R8/R9 irq at expiry", 32'(irq), 32'(fire));
    if (fire) chk("R7 vector", 32'(ivec), 32'(v));
    rd(A_CUR, d);
    chk(per ? "R6 reload" : "R5 reach zero", d, per ? 32'(n) : 0);
    @(negedge clk);
    chk("R7 single pulse", 32'(irq), 0);
    if (per) begin
      early = 1'b0;
      for (int m = 0; m < total - 2; m++) begin
        @(negedge clk);
        if (irq) early = 1'b1;
      end
      chk("R6 no early second irq", 32'(early), 0);
      @(negedge clk);
      chk("R6 second irq", 32'(irq), 32'(fire));
      wr(A_INIT, 0);
      rd(A_CUR, d);
      chk("R4 stop", d, 0);
    end else begin
      repeat (3) @(negedge clk);
      rd(A_CUR, d);
      chk("R5 hold zero", d, 0);
      chk("R5 no repeat irq", 32'(irq), 0);
    end
  endtask

  initial begin
    logic [31:0] d;
    int seed;
    bit early;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rd(A_CTRL, d); chk("R1 ctrl reset", d, 0);
    rd(A_LVT, d);  chk("R1 entry reset", d, 0);
    rd(A_INIT, d); chk("R1 start reset", d, 0);
    rd(A_CUR, d);  chk("R1 count reset", d, 0);
    rd(A_DIV, d);  chk("R1 div reset", d, 0);
    chk("R1 irq reset", 32'(irq), 0);
    chk("R1 vec reset", 32'(ivec), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV, d); chk("R2 div readback", d, 32'h0000_000B);
    wr(A_LVT, 32'hFFFF_FFFF); rd(A_LVT, d); chk("R10 entry readback", d, 32'h0003_00FF);
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); chk("R10 ctrl readback", d, 1);
    wr(A_INIT, 0);
    wr(A_INIT + 8'h4, 0);
    wr(A_NONE, 32'h1234_5678); rd(A_NONE, d); chk("R11 unmapped reads 0", d, 0);
    wr(A_CUR, 32'h55); rd(A_CUR, d); chk("R11 count not writable", d, 0);

    // R4: stop mid-count
    wr(A_LVT, lvt_word(8'h21, 1'b0, 1'b0));
    wr(A_DIV, div_word(7));
    wr(A_INIT, 50);
    rd(A_INIT + 8'h4, d); chk("R10 alias start read", d, 50);
    repeat (5) @(negedge clk);
    wr(A_INIT, 0);
    early = 1'b0;
    for (int m = 0; m < 100; m++) begin
      @(negedge clk);
      if (irq) early = 1'b1;
    end
    chk("R4 no irq after stop", 32'(early), 0);
    rd(A_CUR, d); chk("R4 count zero", d, 0);

    // directed corners
    run(3, 7, 1'b0, 1'b0, 1'b1, 8'h40);   // R2 divide by 1
    run(2, 0, 1'b0, 1'b0, 1'b1, 8'h41);   // R2 divide by 2
    run(2, 6, 1'b0, 1'b0, 1'b1, 8'hFE);   // R2 divide by 128
    run(4, 1, 1'b1, 1'b0, 1'b1, 8'h77);   // R6 periodic
    run(5, 7, 1'b0, 1'b1, 1'b1, 8'h10);   // R8 masked
    run(5, 7, 1'b0, 1'b0, 1'b0, 8'h11);   // R9 disabled
    run(3, 2, 1'b1, 1'b1, 1'b1, 8'h12);   // R8 masked periodic

    for (int i = 0; i < 25; i++) begin
      int n, c;
      bit p, mk, en;
      n  = 2 + int'($urandom_range(10));
      c  = int'($urandom_range(7));
      p  = 1'($urandom_range(1));
      mk = ($urandom_range(3) == 0);
      en = ($urandom_range(3) != 0);
      run(n, c, p, mk, en, 8'($urandom_range(255)));
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule